// File: doc/BRIEF.md
# Banked Three-Wire Control Port

This block is the slave side of a three-wire serial control link for a tuner-style register file. A host drives a serial clock, a direction wire and one shared data line. Each frame carries an 8-bit register address followed by an 8-bit data byte, most significant bit first, with every bit taken on a rising serial clock. All three host wires are brought into the system clock domain through synchronizers. The serial clock is then edge-detected, so the port runs entirely on the fast system clock.

Registers are arranged in three banks. A bank-select register decodes at address 01h in every bank. The selection it holds stays in force across any number of later frames. Writes to defined addresses leave the port as a one-cycle strobe that carries the bank, the low address nibble and the data. The analog controls behind the registers catch these strobes. When the direction wire is low, the port collects the address and then drives eight read bits onto the data line. Its driver is enabled only for those eight bits. Bank 1 holds a fixed identifier and a partly fixed status byte. Its remaining readable addresses come from an external read port.

Top module: `tuner_ctrl_port`

## Requirements
- R1: With the direction wire high, a frame of 16 rising serial edges (address 8 bits, then data 8 bits, MSB first) to a defined address gives exactly one `wr_stb_o` pulse of one system cycle, carrying the current bank, address[3:0] and the data byte.
- R2: Writing 01h, 02h or 03h to address 01h selects that bank, from whichever bank is current. Reset selects bank 01h. The selection persists and tags every later write and read.
- R3: A write to address 01h never raises `wr_stb_o`. A bank number other than 01h..03h leaves the selection unchanged.
- R4: While the direction wire is high, and from a few system cycles after it rises, `ser_dat_oe_o` is 0.
- R5: With the direction wire low, the driver stays off for the first 7 rising edges. After the 8th edge it is on and shows read bit 7. After edge 8+n it shows bit 7-n. After the 16th edge it is off again.
- R6: In bank 01h, reading address 00h returns 07h.
- R7: In bank 01h, reading address 0Ch returns Dh in bits 7:4, 11b in bits 3:2 and `rd_data_i[1:0]` in bits 1:0.
- R8: In bank 01h, reading address 0Ah, 0Bh, 0Dh or 0Eh pulses `rd_stb_o` once with `rd_addr_o` equal to address[3:0] and returns `rd_data_i`.
- R9: Defined write addresses are 02h..06h, 08h, 09h and 0Fh in bank 01h, 02h..0Bh in bank 02h, and 02h..04h in bank 03h. Any address with a nonzero upper nibble is undefined. Writes to undefined addresses give no strobe. Reads of anything not listed in R6..R8 return 00h.
- R10: Any change of the direction wire discards a partial frame, and the next frame starts counting from its first bit.
- R11: After reset the data driver is off and no write strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Host serial clock, asynchronous |
| dir_i | input | 1 | Direction: 1 host writes, 0 port returns read data |
| ser_dat_i | input | 1 | Data line as seen at the pad input |
| ser_dat_o | output | 1 | Read bit driven onto the data line |
| ser_dat_oe_o | output | 1 | Pad output enable for the data line |
| wr_stb_o | output | 1 | One-cycle write strobe to a defined register |
| wr_bank_o | output | 2 | Bank of the write |
| wr_addr_o | output | 4 | Register address within the bank |
| wr_data_o | output | 8 | Written byte |
| rd_stb_o | output | 1 | One-cycle pulse when an externally supplied register is read |
| rd_addr_o | output | 4 | Address of the external read |
| rd_data_i | input | 8 | External read value, used in the cycle `rd_stb_o` is high |

## Verification
The assertions assume that each serial clock phase lasts several times the synchronizer depth in system cycles. They also assume that the data line is steady around each rising serial edge and that the direction wire only moves while the serial clock is low. Under those conditions, no serial edge can fall in the single cycle between address capture and driver load. The stimulus holds each serial phase for 48 system cycles and changes data and direction only between edges. It waits a full phase after every direction change and keeps `rd_data_i` fixed for the whole of a read frame.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 8;
  localparam int LOC_W  = 4;

  localparam logic [REG_AW-1:0] SEL_ADDR = 8'h01;
  localparam logic [REG_DW-1:0] ID_VALUE = 8'h07;
  localparam logic [3:0]        REV_NIB  = 4'hD;

  typedef enum logic [1:0] {
    BANK_NONE = 2'd0,
    BANK_STAT = 2'd1,
    BANK_FM   = 2'd2,
    BANK_AM   = 2'd3
  } bank_e;

  function automatic logic wr_defined(bank_e b, logic [REG_AW-1:0] a);
    if (a[REG_AW-1:LOC_W] != '0) return 1'b0;
    case (b)
      BANK_STAT: return a[LOC_W-1:0] inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h8, 4'h9, 4'hF};
      BANK_FM:   return (a[LOC_W-1:0] >= 4'h2) && (a[LOC_W-1:0] <= 4'hB);
      BANK_AM:   return (a[LOC_W-1:0] >= 4'h2) && (a[LOC_W-1:0] <= 4'h4);
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic rd_external(bank_e b, logic [REG_AW-1:0] a);
    if (a[REG_AW-1:LOC_W] != '0 || b != BANK_STAT) return 1'b0;
    return a[LOC_W-1:0] inside {4'hA, 4'hB, 4'hD, 4'hE};
  endfunction
endpackage

// File: rtl/tcp_sync.sv
module tcp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/tcp_frame.sv
module tcp_frame #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int FRAME = AW + DW,
  localparam int CNT_W = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_s,
  input  logic             dir_s,
  input  logic             sdat_s,
  output logic             rise,
  output logic             dir_chg,
  output logic [CNT_W-1:0] cnt,
  output logic             addr_done,
  output logic             frame_done,
  output logic [AW-1:0]    addr_now,
  output logic [FRAME-1:0] word_now
);
  logic             sclk_q, dir_q;
  logic [FRAME-2:0] sh;

  assign rise       = sclk_s & ~sclk_q;
  assign dir_chg    = dir_s ^ dir_q;
  assign addr_done  = rise & ~dir_chg & (cnt == CNT_W'(AW - 1));
  assign frame_done = rise & ~dir_chg & (cnt == CNT_W'(FRAME - 1));
  assign addr_now   = {sh[AW-2:0], sdat_s};
  assign word_now   = {sh, sdat_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      dir_q  <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
    end else begin
      sclk_q <= sclk_s;
      dir_q  <= dir_s;
      if (dir_chg) begin
        cnt <= '0;
      end else if (rise) begin
        sh  <= {sh[FRAME-3:0], sdat_s};
        cnt <= (cnt == CNT_W'(FRAME - 1)) ? '0 : cnt + 1'b1;
      end
    end
  end

  // R10: a direction change restarts the frame
  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    dir_chg |=> (cnt == '0));
endmodule

// File: rtl/tcp_regmap.sv
module tcp_regmap
  import tcp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dir_s,
  input  logic                    addr_done,
  input  logic                    frame_done,
  input  logic [REG_AW-1:0]       addr_now,
  input  logic [REG_AW+REG_DW-1:0] word_now,
  input  logic [REG_DW-1:0]       rd_data_i,
  output logic                    wr_stb_o,
  output logic [1:0]              wr_bank_o,
  output logic [LOC_W-1:0]        wr_addr_o,
  output logic [REG_DW-1:0]       wr_data_o,
  output logic                    rd_stb_o,
  output logic [LOC_W-1:0]        rd_addr_o,
  output logic                    rd_load,
  output logic [REG_DW-1:0]       rd_byte
);
  bank_e             bank;
  logic [REG_AW-1:0] rd_pend_addr;
  logic [REG_AW-1:0] w_addr;
  logic [REG_DW-1:0] w_data;
  logic              wr_frame, sel_hit, sel_ok, rd_go;

  assign w_addr   = word_now[REG_AW+REG_DW-1:REG_DW];
  assign w_data   = word_now[REG_DW-1:0];
  assign wr_frame = frame_done & dir_s;
  assign sel_hit  = wr_frame && (w_addr == SEL_ADDR);
  assign sel_ok   = (w_data[REG_DW-1:2] == '0) && (w_data[1:0] != 2'b00);
  assign rd_go    = addr_done & ~dir_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank         <= BANK_STAT;
      wr_stb_o     <= 1'b0;
      wr_bank_o    <= '0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      rd_stb_o     <= 1'b0;
      rd_addr_o    <= '0;
      rd_load      <= 1'b0;
      rd_pend_addr <= '0;
    end else begin
      wr_stb_o <= wr_frame && wr_defined(bank, w_addr);
      if (wr_frame && wr_defined(bank, w_addr)) begin
        wr_bank_o <= bank;
        wr_addr_o <= w_addr[LOC_W-1:0];
        wr_data_o <= w_data;
      end
      if (sel_hit && sel_ok) bank <= bank_e'(w_data[1:0]);
      rd_stb_o <= rd_go && rd_external(bank, addr_now);
      rd_load  <= rd_go;
      if (rd_go) begin
        rd_pend_addr <= addr_now;
        rd_addr_o    <= addr_now[LOC_W-1:0];
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    if (rd_pend_addr[REG_AW-1:LOC_W] == '0 && bank == BANK_STAT) begin
      case (rd_pend_addr[LOC_W-1:0])
        4'h0:                   rd_byte = ID_VALUE;
        4'hC:                   rd_byte = {REV_NIB, 2'b11, rd_data_i[1:0]};
        4'hA, 4'hB, 4'hD, 4'hE: rd_byte = rd_data_i;
        default:                rd_byte = '0;
      endcase
    end
  end

  // R2: the selection is always one of the three banks
  assert_bank_legal_R2: assert property (@(posedge clk) disable iff (rst)
    bank != BANK_NONE);
  // R3: only an accepted select write may move the bank
  assert_bank_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(sel_hit && sel_ok) |=> $stable(bank));
  // R3: a select write never leaves as a register strobe
  assert_sel_no_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    sel_hit |=> !wr_stb_o);
  // R1: a write strobe lasts one cycle
  assert_wr_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o);
endmodule

// File: rtl/tcp_tx.sv
module tcp_tx #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int FRAME = AW + DW,
  localparam int CNT_W = $clog2(FRAME)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             dir_s,
  input  logic             dir_chg,
  input  logic [CNT_W-1:0] cnt,
  input  logic             load,
  input  logic [DW-1:0]    rd_byte,
  output logic             sdat_o,
  output logic             sdat_oe
);
  logic [DW-1:0] tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx      <= '0;
      sdat_o  <= 1'b0;
      sdat_oe <= 1'b0;
    end else if (dir_chg || dir_s) begin
      sdat_oe <= 1'b0;
    end else if (load) begin
      tx      <= {rd_byte[DW-2:0], 1'b0};
      sdat_o  <= rd_byte[DW-1];
      sdat_oe <= 1'b1;
    end else if (rise && sdat_oe) begin
      if (cnt == CNT_W'(FRAME - 1)) begin
        sdat_oe <= 1'b0;
      end else begin
        sdat_o <= tx[DW-1];
        tx     <= {tx[DW-2:0], 1'b0};
      end
    end
  end

  // R4: no driving while the host owns the line
  assert_quiet_on_write_R4: assert property (@(posedge clk) disable iff (rst)
    (dir_s && !dir_chg) |-> !sdat_oe);
  // R5: driver only in the data half of a frame
  assert_oe_window_R5: assert property (@(posedge clk) disable iff (rst)
    sdat_oe |-> (cnt >= CNT_W'(AW)));
  // R5: a driven bit moves only on a serial edge
  assert_hold_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (sdat_oe && $past(sdat_oe) && !$past(rise)) |-> $stable(sdat_o));
endmodule

// File: rtl/tuner_ctrl_port.sv
module tuner_ctrl_port
  import tcp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              dir_i,
  input  logic              ser_dat_i,
  output logic              ser_dat_o,
  output logic              ser_dat_oe_o,
  output logic              wr_stb_o,
  output logic [1:0]        wr_bank_o,
  output logic [LOC_W-1:0]  wr_addr_o,
  output logic [REG_DW-1:0] wr_data_o,
  output logic              rd_stb_o,
  output logic [LOC_W-1:0]  rd_addr_o,
  input  logic [REG_DW-1:0] rd_data_i
);
  localparam int FRAME = REG_AW + REG_DW;
  localparam int CNT_W = $clog2(FRAME);

  logic [2:0]        sync_q;
  logic              rise, dir_chg, addr_done, frame_done, rd_load;
  logic [CNT_W-1:0]  cnt;
  logic [REG_AW-1:0] addr_now;
  logic [FRAME-1:0]  word_now;
  logic [REG_DW-1:0] rd_byte;

  tcp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({ser_clk_i, dir_i, ser_dat_i}),
    .q(sync_q)
  );

  tcp_frame #(.AW(REG_AW), .DW(REG_DW)) u_frame (
    .clk(clk), .rst(rst),
    .sclk_s(sync_q[2]), .dir_s(sync_q[1]), .sdat_s(sync_q[0]),
    .rise(rise), .dir_chg(dir_chg), .cnt(cnt),
    .addr_done(addr_done), .frame_done(frame_done),
    .addr_now(addr_now), .word_now(word_now)
  );

  tcp_regmap u_regmap (
    .clk(clk), .rst(rst), .dir_s(sync_q[1]),
    .addr_done(addr_done), .frame_done(frame_done),
    .addr_now(addr_now), .word_now(word_now), .rd_data_i(rd_data_i),
    .wr_stb_o(wr_stb_o), .wr_bank_o(wr_bank_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .rd_stb_o(rd_stb_o), .rd_addr_o(rd_addr_o),
    .rd_load(rd_load), .rd_byte(rd_byte)
  );

  tcp_tx #(.AW(REG_AW), .DW(REG_DW)) u_tx (
    .clk(clk), .rst(rst), .rise(rise), .dir_s(sync_q[1]),
    .dir_chg(dir_chg), .cnt(cnt), .load(rd_load), .rd_byte(rd_byte),
    .sdat_o(ser_dat_o), .sdat_oe(ser_dat_oe_o)
  );

  // R11: quiet outputs in the first cycle after reset
  assert_reset_quiet_R11: assert property (@(posedge clk)
    $past(rst) |-> (!ser_dat_oe_o && !wr_stb_o));
endmodule

// File: tb/test_tuner_ctrl_port.sv
`timescale 1ns/1ps
module test_tuner_ctrl_port;
  localparam int HP = 48;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, dir = 1'b0, sdat = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic ser_dat_o, ser_dat_oe_o, wr_stb_o, rd_stb_o;
  logic [1:0] wr_bank_o;
  logic [3:0] wr_addr_o, rd_addr_o;
  logic [7:0] wr_data_o;

  int checks = 0, fails = 0, bank_m = 1, rd_hits = 0, rd_last = -1;
  bit done = 0;
  typedef struct { int bank; int addr; int data; } wr_t;
  wr_t act_q[$];

  always #2 clk = ~clk;

  tuner_ctrl_port i_tuner_ctrl_port (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .dir_i(dir), .ser_dat_i(sdat),
    .ser_dat_o(ser_dat_o), .ser_dat_oe_o(ser_dat_oe_o),
    .wr_stb_o(wr_stb_o), .wr_bank_o(wr_bank_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .rd_stb_o(rd_stb_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data)
  );

  always @(posedge clk) if (!rst) begin
    if (wr_stb_o) act_q.push_back('{int'(wr_bank_o), int'(wr_addr_o), int'(wr_data_o)});
    if (rd_stb_o) begin rd_hits++; rd_last = int'(rd_addr_o); end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_dir(input bit d);
    if (dir !== d) begin dir = d; cyc(HP); end
  endtask

  function automatic bit wr_def(input int b, input int a);
    if (a > 15) return 0;
    case (b)
      1: return (a >= 2 && a <= 6) || a == 8 || a == 9 || a == 15;
      2: return a >= 2 && a <= 11;
      3: return a >= 2 && a <= 4;
      default: return 0;
    endcase
  endfunction

  function automatic int rd_exp(input int b, input int a, input int ext);
    if (b != 1) return 0;
    case (a)
      0: return 7;
      12: return 8'hDC | (ext & 3);
      10, 11, 13, 14: return ext;
      default: return 0;
    endcase
  endfunction

  task automatic do_write(input int addr, input int data, input string req);
    int word;
    bit exp_stb;
    set_dir(1);
    act_q.delete();
    word = (addr << 8) | data;
    for (int i = 15; i >= 0; i--) begin
      sdat = word[i]; cyc(HP); sclk = 1; cyc(HP); sclk = 0;
    end
    cyc(8);
    exp_stb = wr_def(bank_m, addr);
    chk(ser_dat_oe_o == 0, "R4 driver during write", int'(ser_dat_oe_o), 0);
    if (exp_stb) begin
      chk(act_q.size() == 1, {req, " strobe count"}, act_q.size(), 1);
      if (act_q.size() == 1)
        chk(act_q[0].bank == bank_m && act_q[0].addr == (addr & 15) && act_q[0].data == data,
            {req, " strobe fields"},
            (act_q[0].bank << 16) | (act_q[0].addr << 8) | act_q[0].data,
            (bank_m << 16) | ((addr & 15) << 8) | data);
    end else begin
      chk(act_q.size() == 0, {req, " no strobe"}, act_q.size(), 0);
    end
    if (addr == 1 && data >= 1 && data <= 3) bank_m = data;
  endtask

  task automatic do_read(input int addr, input int ext, input string req);
    int exp, ebit;
    bit ext_hit;
    set_dir(0);
    rd_data = ext[7:0];
    rd_hits = 0;
    exp = rd_exp(bank_m, addr, ext);
    ext_hit = (bank_m == 1) && (addr == 10 || addr == 11 || addr == 13 || addr == 14);
    for (int k = 1; k <= 16; k++) begin
      sdat = (k <= 8) ? addr[8-k] : 1'b0;
      cyc(HP); sclk = 1; cyc(HP/2);
      if (k < 8 || k == 16) begin
        chk(ser_dat_oe_o == 0, "R5 driver off outside data bits", int'(ser_dat_oe_o), 0);
      end else begin
        ebit = (exp >> (15 - k)) & 1;
        chk(ser_dat_oe_o == 1 && int'(ser_dat_o) == ebit, req,
            {30'd0, ser_dat_oe_o, ser_dat_o}, 2 | ebit);
      end
      cyc(HP/2); sclk = 0;
    end
    cyc(8);
    chk(rd_hits == (ext_hit ? 1 : 0), "R8 external read strobe", rd_hits, ext_hit ? 1 : 0);
    if (ext_hit) chk(rd_last == addr, "R8 external read address", rd_last, addr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(10);
    rst = 0;
    cyc(2);
    chk(ser_dat_oe_o == 0, "R11 reset driver", int'(ser_dat_oe_o), 0);
    chk(wr_stb_o == 0, "R11 reset strobe", int'(wr_stb_o), 0);

    do_read(8'h00, 8'h00, "R6 id read in reset bank (R2)");
    do_read(8'h0C, 8'hA6, "R7 status byte");
    do_read(8'h0A, 8'h5A, "R8 external byte");
    do_read(8'h07, 8'hFF, "R9 undefined read is zero");

    do_write(8'h03, 8'hC3, "R1 bank 1 write");
    do_write(8'h07, 8'h11, "R9 undefined address");
    do_write(8'h13, 8'h22, "R9 upper nibble set");
    do_write(8'h01, 8'h02, "R3 select gives no strobe");
    do_write(8'h0B, 8'h5A, "R2 write tagged bank 2");
    do_write(8'h01, 8'h04, "R3 invalid bank number");
    do_write(8'h05, 8'h77, "R3 bank kept after invalid select");
    do_write(8'h01, 8'h00, "R3 zero bank number");
    do_write(8'h06, 8'h3C, "R3 bank kept after zero select");
    do_write(8'h01, 8'h03, "R2 select bank 3");
    do_write(8'h04, 8'h99, "R1 bank 3 write");
    do_write(8'h05, 8'h66, "R9 bank 3 undefined");
    do_read(8'h00, 8'h55, "R9 id absent outside bank 1");

    // R10: partial write frame discarded by a direction change
    set_dir(1);
    for (int i = 0; i < 5; i++) begin
      sdat = 1'b1; cyc(HP); sclk = 1; cyc(HP); sclk = 0;
    end
    set_dir(0);
    do_write(8'h02, 8'hA5, "R10 frame after abort");

    // R10: read aborted once the driver is on
    set_dir(0);
    for (int k = 1; k <= 9; k++) begin
      sdat = 1'b0; cyc(HP); sclk = 1; cyc(HP); sclk = 0;
    end
    set_dir(1);
    chk(ser_dat_oe_o == 0, "R4 driver released on direction change", int'(ser_dat_oe_o), 0);
    do_write(8'h01, 8'h01, "R2 select from bank 3");
    do_read(8'h00, 8'h00, "R6 id after reselect (R10)");
    do_read(8'h0E, 8'h3B, "R8 external after abort");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule